// File: doc/BRIEF.md
# GPIO Bank with Trigger Capture and Interrupt

A bank of up to 32 general-purpose pins behind a 32-bit register port. Each pin has an output latch, a direction bit that enables its output driver, and an input that is sampled through a synchronizer. Software can move single pins with atomic set and clear aliases for the output and direction registers, so no read-modify-write is needed.

Every pin also feeds a trigger detector. Each pin can be set to detect levels or edges, with positive or negative polarity, and edge pins can trigger on both edges. A detected event sets that pin's bit in a capture register. Software clears a capture bit by writing a one to it. The captured bits, gated by a per-pin enable mask, are ORed into one registered interrupt line.

The register port is a simple strobe. A write takes effect on the clock edge where `reg_valid` and `reg_write` are both high. Read data is combinational from `reg_addr` and has no side effects.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low. All pins are therefore inputs with interrupts disabled.
- R2: A write to 0x00 loads the output latch. A write to 0x40 ORs the data into it, and a write to 0x44 clears the bits that are one in the data. `pin_out` follows the latch, and 0x00 reads it back.
- R3: Address 0x08 holds the direction register, where bit value 1 drives the pin (`pin_oe` high) and 0 makes it an input. A write to 0x48 sets the masked bits and a write to 0x4C clears them.
- R4: Address 0x04 returns the pin inputs after a two-flop synchronizer, so a pin change becomes visible after the second rising edge. Writes to 0x04 have no effect.
- R5: For a pin whose bit in the mode register (0x2C) is 0, edges are detected. Polarity bit 0 in register 0x18 selects the rising edge and 1 selects the falling edge. No capture bit sets without a detected event.
- R6: When the pin's bit in the both-edges register (0x1C) is 1, an edge-mode pin captures on both edges, whatever its polarity bit.
- R7: A mode bit of 1 selects level detection: high level when the polarity bit is 0, low level when it is 1. The capture bit is set again on every cycle while the active level lasts.
- R8: Capture register 0x20 is cleared per bit by writing 1, and writing 0 leaves a bit unchanged. When an event and a clear reach a bit in the same cycle, the event wins.
- R9: A write to 0x30 sets enable bits and a write to 0x34 clears them, and 0x30 reads the enable mask. `irq` is the registered OR of capture AND enable, one cycle behind the capture state.
- R10: Reads of 0x34, 0x40, 0x44, 0x48, 0x4C and of any unmapped address return zero. Bits at and above NUM_PINS read as zero in every register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Write when high, with reg_valid |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (direction register) |
| irq | output | 1 | Combined interrupt request |

## Verification
The trigger detector is driven with single-pin rising and falling transitions under each polarity. This shows that the edge polarity is decoded correctly and that the opposite edge is ignored. A both-edges pin whose polarity bit is set to negative shows that the override wins over polarity. High and low steady levels, each with a clear issued while the level is still present, separate level behaviour from edge behaviour: only level mode re-captures after the clear. Zero-data clears, partial clears and enable masking with pending and non-pending bits show which bits reach the interrupt. All of this runs on a 24-pin instance, so reads can also show that the unimplemented upper bits stay zero.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int REG_W = 32;

   localparam logic [7:0] OFS_OUT     = 8'h00;
   localparam logic [7:0] OFS_IN      = 8'h04;
   localparam logic [7:0] OFS_DIR     = 8'h08;
   localparam logic [7:0] OFS_POL     = 8'h18;
   localparam logic [7:0] OFS_BOTH    = 8'h1C;
   localparam logic [7:0] OFS_CAP     = 8'h20;
   localparam logic [7:0] OFS_MODE    = 8'h2C;
   localparam logic [7:0] OFS_EN_SET  = 8'h30;
   localparam logic [7:0] OFS_EN_CLR  = 8'h34;
   localparam logic [7:0] OFS_OUT_SET = 8'h40;
   localparam logic [7:0] OFS_OUT_CLR = 8'h44;
   localparam logic [7:0] OFS_DIR_SET = 8'h48;
   localparam logic [7:0] OFS_DIR_CLR = 8'h4C;

   // how a register write alters a pin-wide vector
   typedef enum logic [1:0] {
      UPD_HOLD  = 2'd0,
      UPD_LOAD  = 2'd1,
      UPD_SET   = 2'd2,
      UPD_CLEAR = 2'd3
   } upd_kind_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] samp_o,
   output logic [W-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] samp_q;
   logic [W-1:0] prev_q;

   if (STAGES == 2) begin : g_two
      logic [W-1:0] meta_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= '0;
            samp_q <= '0;
         end else begin
            meta_q <= raw_i;
            samp_q <= meta_q;
         end
      end
   end else begin : g_chain
      logic [W-1:0] chain_q [STAGES-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES - 1; s++) chain_q[s] <= '0;
            samp_q <= '0;
         end else begin
            chain_q[0] <= raw_i;
            for (int s = 1; s < STAGES - 1; s++) chain_q[s] <= chain_q[s-1];
            samp_q <= chain_q[STAGES-2];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= samp_q;
   end

   assign samp_o = samp_q;
   assign prev_o = prev_q;
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
   parameter int W = 32
) (
   input  logic [W-1:0] samp_i,
   input  logic [W-1:0] prev_i,
   input  logic [W-1:0] level_mode_i,
   input  logic [W-1:0] negative_i,
   input  logic [W-1:0] both_i,
   output logic [W-1:0] evt_o
);
   for (genvar p = 0; p < W; p++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      always_comb begin
         rise     = samp_i[p] & ~prev_i[p];
         fall     = ~samp_i[p] & prev_i[p];
         lvl_hit  = negative_i[p] ? ~samp_i[p] : samp_i[p];
         if (both_i[p]) edge_hit = rise | fall;
         else           edge_hit = negative_i[p] ? fall : rise;
         evt_o[p] = level_mode_i[p] ? lvl_hit : edge_hit;
      end
   end
endmodule

// File: rtl/gpio_capture_irq.sv
module gpio_capture_irq #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_mask_i,
   input  logic [W-1:0] en_i,
   output logic [W-1:0] cap_o,
   output logic         irq_o
);
   logic [W-1:0] cap_q;
   logic [W-1:0] clr_eff;
   logic         irq_q;

   assign clr_eff = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
         irq_q <= 1'b0;
      end else begin
         cap_q <= (cap_q & ~clr_eff) | evt_i;
         irq_q <= |(cap_q & en_i);
      end
   end

   assign cap_o = cap_q;
   assign irq_o = irq_q;

   AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((cap_q & $past(evt_i)) == $past(evt_i))); // R8
   AST_NO_PHANTOM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cap_q & ~$past(cap_q) & ~$past(evt_i)) == '0)); // R5
   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cap_q & en_i) != '0) |=> irq_o); // R9
   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ((cap_q & en_i) == '0) |=> !irq_o); // R9
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_valid,
   input  logic                reg_write,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   if (NUM_PINS < 1 || NUM_PINS > REG_W) begin : g_bad_pins
      $error("gpio_irq_bank: NUM_PINS must be 1..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W too narrow for the register map");
   end

   localparam logic [ADDR_W-1:0] A_OUT     = ADDR_W'(OFS_OUT);
   localparam logic [ADDR_W-1:0] A_IN      = ADDR_W'(OFS_IN);
   localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_POL     = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_BOTH    = ADDR_W'(OFS_BOTH);
   localparam logic [ADDR_W-1:0] A_CAP     = ADDR_W'(OFS_CAP);
   localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_EN_SET  = ADDR_W'(OFS_EN_SET);
   localparam logic [ADDR_W-1:0] A_EN_CLR  = ADDR_W'(OFS_EN_CLR);
   localparam logic [ADDR_W-1:0] A_OUT_SET = ADDR_W'(OFS_OUT_SET);
   localparam logic [ADDR_W-1:0] A_OUT_CLR = ADDR_W'(OFS_OUT_CLR);
   localparam logic [ADDR_W-1:0] A_DIR_SET = ADDR_W'(OFS_DIR_SET);
   localparam logic [ADDR_W-1:0] A_DIR_CLR = ADDR_W'(OFS_DIR_CLR);

   function automatic logic [REG_W-1:0] widen(input logic [NUM_PINS-1:0] v);
      logic [REG_W-1:0] r;
      r = '0;
      r[NUM_PINS-1:0] = v;
      return r;
   endfunction

   function automatic logic [NUM_PINS-1:0] apply(input upd_kind_t k,
                                                 input logic [NUM_PINS-1:0] cur,
                                                 input logic [NUM_PINS-1:0] m);
      case (k)
         UPD_LOAD:  return m;
         UPD_SET:   return cur | m;
         UPD_CLEAR: return cur & ~m;
         default:   return cur;
      endcase
   endfunction

   logic                wr;
   logic [NUM_PINS-1:0] wmask;
   upd_kind_t           out_upd, dir_upd, en_upd;
   logic                pol_we, both_we, mode_we, cap_we;

   logic [NUM_PINS-1:0] out_q, dir_q, pol_q, both_q, mode_q, en_q;
   logic [NUM_PINS-1:0] samp, prev, evt, cap;

   assign wr    = reg_valid & reg_write;
   assign wmask = reg_wdata[NUM_PINS-1:0];

   always_comb begin
      out_upd = UPD_HOLD;
      dir_upd = UPD_HOLD;
      en_upd  = UPD_HOLD;
      pol_we  = 1'b0;
      both_we = 1'b0;
      mode_we = 1'b0;
      cap_we  = 1'b0;
      if (wr) begin
         case (reg_addr)
            A_OUT:     out_upd = UPD_LOAD;
            A_OUT_SET: out_upd = UPD_SET;
            A_OUT_CLR: out_upd = UPD_CLEAR;
            A_DIR:     dir_upd = UPD_LOAD;
            A_DIR_SET: dir_upd = UPD_SET;
            A_DIR_CLR: dir_upd = UPD_CLEAR;
            A_EN_SET:  en_upd  = UPD_SET;
            A_EN_CLR:  en_upd  = UPD_CLEAR;
            A_POL:     pol_we  = 1'b1;
            A_BOTH:    both_we = 1'b1;
            A_MODE:    mode_we = 1'b1;
            A_CAP:     cap_we  = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         en_q   <= '0;
         pol_q  <= '0;
         both_q <= '0;
         mode_q <= '0;
      end else begin
         out_q <= apply(out_upd, out_q, wmask);
         dir_q <= apply(dir_upd, dir_q, wmask);
         en_q  <= apply(en_upd, en_q, wmask);
         if (pol_we)  pol_q  <= wmask;
         if (both_we) both_q <= wmask;
         if (mode_we) mode_q <= wmask;
      end
   end

   gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_in),
      .samp_o (samp),
      .prev_o (prev)
   );

   gpio_event_detect #(.W(NUM_PINS)) u_detect (
      .samp_i       (samp),
      .prev_i       (prev),
      .level_mode_i (mode_q),
      .negative_i   (pol_q),
      .both_i       (both_q),
      .evt_o        (evt)
   );

   gpio_capture_irq #(.W(NUM_PINS)) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .clr_we_i   (cap_we),
      .clr_mask_i (wmask),
      .en_i       (en_q),
      .cap_o      (cap),
      .irq_o      (irq)
   );

   always_comb begin
      case (reg_addr)
         A_OUT:    reg_rdata = widen(out_q);
         A_IN:     reg_rdata = widen(samp);
         A_DIR:    reg_rdata = widen(dir_q);
         A_POL:    reg_rdata = widen(pol_q);
         A_BOTH:   reg_rdata = widen(both_q);
         A_CAP:    reg_rdata = widen(cap);
         A_MODE:   reg_rdata = widen(mode_q);
         A_EN_SET: reg_rdata = widen(en_q);
         default:  reg_rdata = '0;
      endcase
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   AST_OUT_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == A_OUT_CLR) |=> ((pin_out & $past(wmask)) == '0)); // R2
   AST_OUT_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == A_OUT_SET) |=> ((pin_out & $past(wmask)) == $past(wmask))); // R2
   AST_DIR_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == A_DIR_SET) |=> ((pin_oe & $past(wmask)) == $past(wmask))); // R3
   AST_INPUT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && reg_addr == A_IN) |=> ($stable(pin_out) && $stable(pin_oe))); // R4
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_valid = 1'b0;
   logic          reg_write = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] pins = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_bank #(.NUM_PINS(NP)) i_gpio_irq_bank (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      expect_reg("R1 out", 8'h00, 0);
      expect_reg("R1 dir", 8'h08, 0);
      expect_reg("R1 cap", 8'h20, 0);
      expect_reg("R1 en", 8'h30, 0);
      check("R1 pin_oe", 32'(pin_oe), 0);
      check("R1 pin_out", 32'(pin_out), 0);
      check("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_output;
      wr(8'h00, 32'h0000F0);
      check("R2 load pin_out", 32'(pin_out), 32'h0000F0);
      wr(8'h40, 32'h3);
      check("R2 set alias", 32'(pin_out), 32'h0000F3);
      wr(8'h44, 32'h10);
      expect_reg("R2 clear alias readback", 8'h00, 32'h0000E3);
   endtask

   task automatic t_direction;
      wr(8'h48, 32'h5);
      wr(8'h4C, 32'h1);
      check("R3 pin_oe", 32'(pin_oe), 32'h4);
      expect_reg("R3 dir read", 8'h08, 32'h4);
      wr(8'h08, 32'hFFFF_FFFF);
      expect_reg("R10 upper bits zero", 8'h08, 32'h00FF_FFFF);
      wr(8'h08, 32'h0);
      check("R3 all inputs", 32'(pin_oe), 0);
   endtask

   task automatic t_input;
      logic [31:0] d;
      @(negedge clk);
      pins = 24'hABCDEF;
      @(negedge clk);
      #1 reg_addr = 8'h04;
      #1 d = reg_rdata;
      check("R4 not yet after one edge", d, 0);
      expect_reg("R4 synced after two edges", 8'h04, 32'h00ABCDEF);
      wr(8'h04, 32'h0);
      expect_reg("R4 write ignored", 8'h04, 32'h00ABCDEF);
      @(negedge clk);
      pins = '0;
      settle(4);
      wr(8'h20, 32'hFFFFFF);
      expect_reg("R8 cleared all", 8'h20, 0);
   endtask

   task automatic t_edge;
      @(negedge clk); pins[0] = 1'b1;
      settle(4);
      expect_reg("R5 rising captured", 8'h20, 32'h1);
      wr(8'h20, 32'h1);
      @(negedge clk); pins[0] = 1'b0;
      settle(4);
      expect_reg("R5 falling ignored in rise mode", 8'h20, 0);
      wr(8'h18, 32'h2);
      @(negedge clk); pins[1] = 1'b1;
      settle(4);
      expect_reg("R5 rising ignored in fall mode", 8'h20, 0);
      @(negedge clk); pins[1] = 1'b0;
      settle(4);
      expect_reg("R5 falling captured", 8'h20, 32'h2);
      wr(8'h20, 32'h2);
   endtask

   task automatic t_both;
      wr(8'h1C, 32'h4);
      wr(8'h18, 32'h6);
      @(negedge clk); pins[2] = 1'b1;
      settle(4);
      expect_reg("R6 rise with negative polarity", 8'h20, 32'h4);
      wr(8'h20, 32'h4);
      expect_reg("R6 cleared", 8'h20, 0);
      @(negedge clk); pins[2] = 1'b0;
      settle(4);
      expect_reg("R6 fall captured", 8'h20, 32'h4);
      wr(8'h20, 32'h4);
      wr(8'h1C, 32'h0);
   endtask

   task automatic t_level;
      wr(8'h2C, 32'h8);
      @(negedge clk); pins[3] = 1'b1;
      settle(4);
      expect_reg("R7 high level captured", 8'h20, 32'h8);
      wr(8'h20, 32'h8);
      expect_reg("R7 re-asserts, R8 event wins clear", 8'h20, 32'h8);
      @(negedge clk); pins[3] = 1'b0;
      settle(4);
      wr(8'h20, 32'h8);
      expect_reg("R7 clear sticks after level gone", 8'h20, 0);
      wr(8'h18, 32'hE);
      settle(2);
      expect_reg("R7 low level captured", 8'h20, 32'h8);
      wr(8'h2C, 32'h0);
      wr(8'h20, 32'h8);
      expect_reg("R7 edge mode no recapture", 8'h20, 0);
      wr(8'h18, 32'h0);
   endtask

   task automatic t_w1c;
      @(negedge clk); pins[0] = 1'b1;
      settle(4);
      @(negedge clk); pins[4] = 1'b1;
      settle(4);
      expect_reg("R8 two captured", 8'h20, 32'h11);
      wr(8'h20, 32'h0);
      expect_reg("R8 zero write no effect", 8'h20, 32'h11);
      wr(8'h20, 32'h1);
      expect_reg("R8 partial clear", 8'h20, 32'h10);
   endtask

   task automatic t_irq;
      check("R9 disabled no irq", 32'(irq), 0);
      wr(8'h30, 32'h10);
      settle(2);
      check("R9 irq asserted", 32'(irq), 1);
      expect_reg("R9 enable readback", 8'h30, 32'h10);
      wr(8'h34, 32'h10);
      settle(2);
      check("R9 enable clear drops irq", 32'(irq), 0);
      wr(8'h30, 32'h11);
      settle(2);
      check("R9 re-enable", 32'(irq), 1);
      wr(8'h20, 32'h10);
      settle(2);
      check("R9 capture clear drops irq", 32'(irq), 0);
      expect_reg("R9 enable mask", 8'h30, 32'h11);
   endtask

   task automatic t_alias;
      expect_reg("R10 en clear reads 0", 8'h34, 0);
      expect_reg("R10 out set reads 0", 8'h40, 0);
      expect_reg("R10 out clear reads 0", 8'h44, 0);
      expect_reg("R10 dir set reads 0", 8'h48, 0);
      expect_reg("R10 dir clear reads 0", 8'h4C, 0);
      expect_reg("R10 unmapped reads 0", 8'h10, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle(2);
      t_reset();
      t_output();
      t_direction();
      t_input();
      t_edge();
      t_both();
      t_level();
      t_w1c();
      t_irq();
      t_alias();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule